// File: doc/BRIEF.md
# External Interrupt Detector with Noise Filter

This block turns four external interrupt pins of a small 8-bit controller into prioritised interrupt requests. Every pin passes through a two-stage synchronizer. Pin 3 then goes through a sampling noise filter whose sample rate is either the instruction clock or one sixteenth of it. Each pin has its own trigger mode. Pins 0 and 1 offer edge and level modes. Pins 2 and 3 offer single-edge and dual-edge modes. A qualified event raises a per-pin pending flag.

The enabled pending flags go through a fixed-priority encoder, where pin 0 wins and pin 3 loses. The encoder presents a request line and the vector address of the winner. The vectors start at 03h and are 8 bytes apart. The CPU clears an edge flag by acknowledging its index. Pins 2 and 3 also produce a one-cycle count pulse for an event timer on every qualified edge. Mode, enable and filter-rate settings are loaded together through a single write strobe. They take effect on the cycle after the write.

Top module: `ext_irq_unit`

## Requirements
- R1: For pins 0 and 1, mode code 00 flags a rising edge and mode code 01 flags a falling edge. The mode of pin i sits in `cfg_mode_i[2i+1:2i]`.
- R2: For pins 0 and 1, mode code 10 is active-high level and mode code 11 is active-low level. In these modes the flag follows the synchronized pin, and an acknowledge cannot clear it while the active level lasts.
- R3: For pins 2 and 3, code 00 is rising edge and code 01 is falling edge. Codes 10 and 11 both flag every transition.
- R4: An edge-mode flag stays set until an acknowledge arrives with `ack_valid_i` high and `ack_idx_i` equal to the pin index. A new event in the same cycle as its acknowledge keeps the flag set.
- R5: When any enabled flag is pending, `irq_o` is 1 and `vec_o` equals 03h + 8×i, where i is the lowest-numbered enabled pending pin. With none pending, `irq_o` is 0 and `vec_o` is 00h.
- R6: A pin whose enable bit (`cfg_en_i[i]`) is 0 still sets its flag on `flags_o`, but it takes no part in `irq_o` or `vec_o`.
- R7: A pulse one instruction cycle wide on pin 0, 1 or 2 is captured.
- R8: With the filter at full rate (`cfg_slow_i`=0), a 2-cycle pulse on pin 3 is captured and a 1-cycle pulse is rejected.
- R9: With the filter at 1/16 rate (`cfg_slow_i`=1), a 32-cycle pulse on pin 3 is captured and a 15-cycle pulse is rejected.
- R10: Every qualified edge on pin 2 or pin 3 gives exactly one single-cycle pulse on `tmr_evt_o`. Events on pins 0 and 1 never pulse it.
- R11: After reset all flags are clear, `irq_o` and `tmr_evt_o` are 0, `vec_o` is 00h, all enables are off and all modes are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 4 | Raw interrupt pins, bit i is pin i |
| cfg_we_i | input | 1 | Loads mode, enable and filter-rate settings |
| cfg_mode_i | input | 8 | Two-bit trigger mode per pin |
| cfg_en_i | input | 4 | Per-pin request enable |
| cfg_slow_i | input | 1 | Pin 3 filter rate: 0 full, 1 one-sixteenth |
| ack_valid_i | input | 1 | CPU acknowledge strobe |
| ack_idx_i | input | 2 | Index of the pin being acknowledged |
| irq_o | output | 1 | Enabled request pending |
| vec_o | output | 8 | Vector address of the winning request |
| flags_o | output | 4 | Pending flags, enabled or not |
| tmr_evt_o | output | 1 | Timer count pulse from pins 2 and 3 |

## Verification
The bench probes the opposite edge of each edge mode. A detector that ignores polarity would flag a step in the wrong direction. It acknowledges a level flag while the level is still active, which exposes a design that treats level requests as latched. It drives glitches just below and pulses just at the acceptance width of both filter rates. An off-by-one in the sample counter or the agreement rule would then miss a real pulse or let a glitch through. It also counts timer pulses across a dual-edge pulse, where a missing or stretched pulse changes the count. It retires stacked requests one at a time, which catches a wrong priority order or a vector stuck at the first winner.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    typedef enum logic [1:0] {
        TRG_RISE = 2'b00,
        TRG_FALL = 2'b01,
        TRG_ALT0 = 2'b10,
        TRG_ALT1 = 2'b11
    } trig_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t s_q, s_d;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = d_i;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_o = s_q.s2;
endmodule

// File: rtl/eirq_nfilt.sv
module eirq_nfilt #(
    parameter int DIV_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic slow_i,
    output logic filt_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             smp;
        logic             filt;
    } nf_t;

    nf_t  s_q, s_d;
    logic tick;

    always_comb begin
        s_d     = s_q;
        tick    = slow_i ? (&s_q.cnt) : 1'b1;
        s_d.cnt = s_q.cnt + 1'b1;
        if (tick) begin
            s_d.smp = raw_i;
            // two consecutive samples must agree before the level moves
            if (raw_i == s_q.smp) s_d.filt = raw_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign filt_o = s_q.filt;
endmodule

// File: rtl/eirq_trig.sv
module eirq_trig
    import eirq_pkg::*;
#(
    parameter bit LEVEL_OK = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    input  logic [1:0] mode_i,
    input  logic       ack_i,
    output logic       flag_o,
    output logic       evt_o
);
    typedef struct packed {
        logic prev;
        logic flag;
        logic evt;
    } trg_t;

    trg_t s_q, s_d;
    logic rise, fall, hit, lvl_mode, lvl_act;

    always_comb begin
        s_d      = s_q;
        rise     = lvl_i & ~s_q.prev;
        fall     = ~lvl_i & s_q.prev;
        lvl_mode = LEVEL_OK && mode_i[1];
        lvl_act  = mode_i[0] ? ~lvl_i : lvl_i;
        case (trig_e'(mode_i))
            TRG_RISE: hit = rise;
            TRG_FALL: hit = fall;
            default:  hit = LEVEL_OK ? 1'b0 : (rise | fall);
        endcase
        s_d.prev = lvl_i;
        s_d.evt  = hit;
        if (lvl_mode) s_d.flag = lvl_act;
        else          s_d.flag = hit | (s_q.flag & ~ack_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag_o = s_q.flag;
    assign evt_o  = s_q.evt;
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit #(
    parameter int         DIV_W      = 4,
    parameter int         FILT_PIN   = 3,
    parameter logic [3:0] LEVEL_MASK = 4'b0011,
    parameter logic [3:0] EVT_MASK   = 4'b1100,
    parameter logic [7:0] VEC_BASE   = 8'h03,
    parameter logic [7:0] VEC_STEP   = 8'h08
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] pin_i,
    input  logic       cfg_we_i,
    input  logic [7:0] cfg_mode_i,
    input  logic [3:0] cfg_en_i,
    input  logic       cfg_slow_i,
    input  logic       ack_valid_i,
    input  logic [1:0] ack_idx_i,
    output logic       irq_o,
    output logic [7:0] vec_o,
    output logic [3:0] flags_o,
    output logic       tmr_evt_o
);
    localparam int NPIN   = 4;
    localparam int IDX_W  = $clog2(NPIN);
    localparam int MODE_W = 2 * NPIN;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [NPIN-1:0]   en;
        logic              slow;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we_i) begin
            cfg_d.mode = cfg_mode_i;
            cfg_d.en   = cfg_en_i;
            cfg_d.slow = cfg_slow_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    logic [NPIN-1:0] sy, lvl, flag, evt;
    logic            filt;

    eirq_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (sy)
    );

    eirq_nfilt #(.DIV_W(DIV_W)) u_nfilt (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (sy[FILT_PIN]),
        .slow_i (cfg_q.slow),
        .filt_o (filt)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        if (i == FILT_PIN) begin : g_f
            assign lvl[i] = filt;
        end else begin : g_s
            assign lvl[i] = sy[i];
        end
        eirq_trig #(.LEVEL_OK(LEVEL_MASK[i])) u_trig (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (lvl[i]),
            .mode_i (cfg_q.mode[2*i +: 2]),
            .ack_i  (ack_valid_i && (ack_idx_i == IDX_W'(i))),
            .flag_o (flag[i]),
            .evt_o  (evt[i])
        );
    end

    always_comb begin
        irq_o = 1'b0;
        vec_o = '0;
        for (int i = NPIN - 1; i >= 0; i--) begin
            if (flag[i] && cfg_q.en[i]) begin
                irq_o = 1'b1;
                vec_o = VEC_BASE + (8'(i) * VEC_STEP);
            end
        end
    end

    assign flags_o   = flag;
    assign tmr_evt_o = |(evt & EVT_MASK);
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] flags,
    input logic       irq,
    input logic [7:0] vec,
    input logic       tmr,
    input logic       ack_valid,
    input logic [1:0] ack_idx
);
    assert_vec_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vec == 8'h03 || vec == 8'h0B || vec == 8'h13 || vec == 8'h1B));

    assert_vec_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (vec == 8'h00));

    assert_sticky2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[2] && !(ack_valid && ack_idx == 2'd2)) |=> flags[2]);

    assert_sticky3_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[3] && !(ack_valid && ack_idx == 2'd3)) |=> flags[3]);

    assert_tmr_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tmr |-> (flags[3:2] != 2'b00));
endmodule

bind ext_irq_unit eirq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags     (flags_o),
    .irq       (irq_o),
    .vec       (vec_o),
    .tmr       (tmr_evt_o),
    .ack_valid (ack_valid_i),
    .ack_idx   (ack_idx_i)
);

// File: tb/ext_irq_unit_bench.sv
`timescale 1ns/1ps
module ext_irq_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin = '0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_mode = '0;
    logic [3:0] cfg_en = '0;
    logic       cfg_slow = 1'b0;
    logic       ack_valid = 1'b0;
    logic [1:0] ack_idx = '0;
    logic       irq;
    logic [7:0] vec;
    logic [3:0] flags;
    logic       tmr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ext_irq_unit u_ext_irq_unit (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .cfg_we_i(cfg_we),
        .cfg_mode_i(cfg_mode), .cfg_en_i(cfg_en), .cfg_slow_i(cfg_slow),
        .ack_valid_i(ack_valid), .ack_idx_i(ack_idx), .irq_o(irq),
        .vec_o(vec), .flags_o(flags), .tmr_evt_o(tmr)
    );

    // entry: {pin[1:0], mode[1:0], from, to, expected flag, spare}
    localparam logic [7:0] TBL [12] = '{
        {2'd0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0},
        {2'd0, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd0, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0},
        {2'd1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0},
        {2'd2, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0},
        {2'd2, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd2, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0},
        {2'd2, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0},
        {2'd3, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0},
        {2'd3, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd3, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [7:0] m, input logic [3:0] e, input logic s);
        cfg_we = 1'b1; cfg_mode = m; cfg_en = e; cfg_slow = s;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic ack(input int idx);
        ack_valid = 1'b1; ack_idx = 2'(idx);
        tick(1);
        ack_valid = 1'b0;
    endtask

    task automatic clear_all(input logic s);
        pin = '0;
        cfg(8'h00, 4'hF, s);
        tick(40);
        for (int i = 0; i < 4; i++) ack(i);
    endtask

    task automatic pulse(input int p, input int w);
        pin[p] = 1'b1;
        tick(w);
        pin[p] = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(4);
        // R11: reset state
        chk(flags == 4'h0, "R11 flags", int'(flags), 0);
        chk(irq == 1'b0,   "R11 irq",   int'(irq), 0);
        chk(vec == 8'h00,  "R11 vec",   int'(vec), 0);
        chk(tmr == 1'b0,   "R11 tmr",   int'(tmr), 0);
        rst_n = 1'b1;
        tick(4);
        chk(flags == 4'h0, "R11 flags after release", int'(flags), 0);

        // table of edge-mode vectors (R1 for pins 0/1, R3 for pins 2/3)
        for (int k = 0; k < 12; k++) begin
            logic [7:0] e;
            logic [7:0] m;
            int p;
            e = TBL[k];
            p = int'(e[7:6]);
            m = '0;
            m[2*p +: 2] = e[5:4];
            pin[p] = e[3];
            cfg(m, 4'hF, 1'b0);
            tick(12);
            ack(p);
            tick(2);
            pin[p] = e[2];
            tick(12);
            chk(flags[p] == e[1], (p < 2) ? "R1 edge mode" : "R3 edge mode",
                int'(flags[p]), int'(e[1]));
        end

        // R2: level modes on pin 0
        clear_all(1'b0);
        cfg(8'b0000_0010, 4'hF, 1'b0);
        pin[0] = 1'b1;
        tick(6);
        chk(flags[0] == 1'b1, "R2 high level sets", int'(flags[0]), 1);
        ack(0);
        tick(1);
        chk(flags[0] == 1'b1, "R2 ack ignored while high", int'(flags[0]), 1);
        pin[0] = 1'b0;
        tick(6);
        chk(flags[0] == 1'b0, "R2 flag follows pin low", int'(flags[0]), 0);
        cfg(8'b0000_0011, 4'hF, 1'b0);
        tick(4);
        chk(flags[0] == 1'b1, "R2 low level sets", int'(flags[0]), 1);
        pin[0] = 1'b1;
        tick(6);
        chk(flags[0] == 1'b0, "R2 low level released", int'(flags[0]), 0);

        // R4 and R5: stacked requests, retired in priority order
        clear_all(1'b0);
        pin = 4'b1110;
        tick(12);
        chk(flags == 4'b1110, "R4 flags held until ack", int'(flags), 14);
        chk(vec == 8'h0B, "R5 vector pin1", int'(vec), 11);
        ack(1);
        chk(vec == 8'h13, "R5 vector pin2", int'(vec), 19);
        ack(2);
        chk(vec == 8'h1B, "R5 vector pin3", int'(vec), 27);
        ack(3);
        chk(irq == 1'b0 && vec == 8'h00, "R5 idle after acks", int'(vec), 0);

        // R6: disabled pin sets its flag without requesting
        clear_all(1'b0);
        cfg(8'h00, 4'h0, 1'b0);
        pin[0] = 1'b1;
        tick(8);
        chk(flags[0] == 1'b1, "R6 disabled flag set", int'(flags[0]), 1);
        chk(irq == 1'b0, "R6 no request when disabled", int'(irq), 0);
        cfg(8'h00, 4'h1, 1'b0);
        chk(irq == 1'b1 && vec == 8'h03, "R6 request after enable", int'(vec), 3);

        // R7: single-cycle pulses on pins 1 and 2
        clear_all(1'b0);
        pulse(1, 1);
        pulse(2, 1);
        tick(10);
        chk(flags[1] == 1'b1, "R7 pin1 one-cycle pulse", int'(flags[1]), 1);
        chk(flags[2] == 1'b1, "R7 pin2 one-cycle pulse", int'(flags[2]), 1);

        // R8: full-rate filter on pin 3
        clear_all(1'b0);
        pulse(3, 1);
        tick(12);
        chk(flags[3] == 1'b0, "R8 one-cycle glitch rejected", int'(flags[3]), 0);
        pulse(3, 2);
        tick(12);
        chk(flags[3] == 1'b1, "R8 two-cycle pulse accepted", int'(flags[3]), 1);

        // R9: 1/16 filter on pin 3
        clear_all(1'b1);
        pulse(3, 15);
        tick(40);
        chk(flags[3] == 1'b0, "R9 15-cycle glitch rejected", int'(flags[3]), 0);
        pulse(3, 32);
        tick(40);
        chk(flags[3] == 1'b1, "R9 32-cycle pulse accepted", int'(flags[3]), 1);

        // R10: timer event pulses
        clear_all(1'b0);
        begin
            int n;
            n = 0;
            pin[1:0] = 2'b11;
            for (int i = 0; i < 12; i++) begin @(negedge clk); if (tmr) n++; end
            chk(n == 0, "R10 pins 0/1 give no pulse", n, 0);
            n = 0;
            pin[2] = 1'b1;
            for (int i = 0; i < 12; i++) begin @(negedge clk); if (tmr) n++; end
            chk(n == 1, "R10 pin2 rising one pulse", n, 1);
            pin[2] = 1'b0;
            cfg(8'b0010_0000, 4'hF, 1'b0);
            tick(8);
            n = 0;
            pin[2] = 1'b1;
            for (int i = 0; i < 4; i++) begin @(negedge clk); if (tmr) n++; end
            pin[2] = 1'b0;
            for (int i = 0; i < 12; i++) begin @(negedge clk); if (tmr) n++; end
            chk(n == 2, "R10 pin2 both edges two pulses", n, 2);
            n = 0;
            pin[3] = 1'b1;
            for (int i = 0; i < 12; i++) begin @(negedge clk); if (tmr) n++; end
            chk(n == 1, "R10 pin3 rising one pulse", n, 1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule